// File: doc/BRIEF.md
# PCI Configuration Cycle Address Former

This block turns one host request for configuration space into the address, byte enables and write data of a single PCI configuration cycle. It takes a bus number, a device slot, a function, a register offset, an access size and a direction. It drives a request to a downstream PCI master through a simple request and response handshake, then hands the result back to the host. The result is read data aligned to bit 0, or a master-abort indication.

A request for bus 0 becomes a type-0 cycle. The target is picked by a single IDSEL line, bit (slot + 11) of the address. A request for any other bus becomes a type-1 cycle. It carries the bus, slot, function and register fields packed into the address. While a type-1 cycle is outstanding, the block drives a mode bit in an extension control word and presents that word on `ext_ctl`. Once the cycle finishes, `ext_ctl` returns to the value supplied on `ctl_base`. The block handles one request at a time. Bus 0 slots that no IDSEL line can reach end at once as an abort, and no cycle is issued for them.

Top module: `cfg_cycle_former`

## Requirements
- R1: For a non-zero bus, `cyc_addr` = bus*2^16 + slot*2^11 + func*2^8 + reg, and `cyc_type1` is 1 while `cyc_req` is high.
- R2: For bus 0 with slot below 12, `cyc_addr` = 2^(slot+11) + func*2^8 + reg, and `cyc_type1` is 0. Bits 31 down to 11 of the address then hold exactly one set bit.
- R3: While a type-1 cycle is outstanding, `ext_ctl` equals the `ctl_base` value captured at acceptance with bit 30 set. Otherwise `ext_ctl` equals `ctl_base`, including from the cycle in which the completion is reported.
- R4: A bus 0 request with slot 12 or above raises no `cyc_req`. It reports `cpl_valid` with `cpl_abort` in the cycle after acceptance.
- R5: `req_size` encodes 0 = byte, 1 = 16-bit and 2 or 3 = 32-bit. The lane is `reg[1:0]` for a byte, `{reg[1],0}` for 16-bit and 0 for 32-bit. `cyc_be` has one bit per byte and is set for the bytes the access covers. `cyc_wdata` carries the low bytes of `req_wdata`, shifted to the lane.
- R6: A read that completes without abort returns the response bytes of its lane on `cpl_rdata`, shifted to bit 0 and zero-extended above the access width.
- R7: A read that aborts, through the response or through R4, returns all ones at the requested width and zeros above it.
- R8: A write that aborts pulses `wr_err` for exactly the completion cycle. A write that completes normally leaves `wr_err` low. A write returns 0 on `cpl_rdata`.
- R9: `busy` is high from acceptance until the response is taken. A request presented while `busy` is high is ignored: the cycle outputs stay unchanged, and no further cycle follows the completion.
- R10: After reset, `busy`, `cyc_req`, `cpl_valid` and `wr_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_bus | input | 8 | Target bus number |
| req_slot | input | 5 | Device slot |
| req_func | input | 3 | Function number |
| req_reg | input | 8 | Register byte offset |
| req_size | input | 2 | Access size (0 byte, 1 16-bit, 2/3 32-bit) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data, low-aligned |
| ctl_base | input | 32 | Resting value of the extension control word |
| busy | output | 1 | Request outstanding; new requests ignored |
| ext_ctl | output | 32 | Extension control word in effect |
| cyc_req | output | 1 | Cycle request to the PCI master, held until response |
| cyc_type1 | output | 1 | Cycle is type-1 |
| cyc_write | output | 1 | Cycle direction |
| cyc_addr | output | 32 | Configuration cycle address |
| cyc_be | output | 4 | Byte enables, active high |
| cyc_wdata | output | 32 | Lane-aligned write data |
| rsp_valid | input | 1 | Response from the PCI master |
| rsp_abort | input | 1 | Response is a master-abort |
| rsp_rdata | input | 32 | Response read data, lane-aligned |
| cpl_valid | output | 1 | One-cycle completion to the host |
| cpl_abort | output | 1 | Completion was an abort |
| cpl_rdata | output | 32 | Completion read data, low-aligned |
| wr_err | output | 1 | One-cycle pulse for an aborted write |

## Verification
Every request field is latched once at acceptance. A corrupted latch therefore shows on `cyc_addr` or `cyc_be` in the first cycle `cyc_req` is high, one clock after the request. A lost or stale type-1 flag shows in that same cycle as a wrong `ext_ctl` value or a wrong address form. A broken lane or size register only shows one clock after the response, in `cpl_rdata` or `wr_err`. If the busy state is lost, the next request presented during a wait changes `cyc_addr` one clock later. If the busy state sticks, `busy` is seen high in the completion cycle.

// File: rtl/cfg_cycle_former.sv
module cfg_cycle_former #(
  parameter int BUS_W      = 8,
  parameter int SLOT_W     = 5,
  parameter int FUNC_W     = 3,
  parameter int REG_W      = 8,
  parameter int MAX_SLOTS  = 12,
  parameter int IDSEL_BASE = 11,
  parameter int EXT_BIT    = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [BUS_W-1:0]  req_bus,
  input  logic [SLOT_W-1:0] req_slot,
  input  logic [FUNC_W-1:0] req_func,
  input  logic [REG_W-1:0]  req_reg,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [31:0]       req_wdata,
  input  logic [31:0]       ctl_base,
  output logic              busy,
  output logic [31:0]       ext_ctl,
  output logic              cyc_req,
  output logic              cyc_type1,
  output logic              cyc_write,
  output logic [31:0]       cyc_addr,
  output logic [3:0]        cyc_be,
  output logic [31:0]       cyc_wdata,
  input  logic              rsp_valid,
  input  logic              rsp_abort,
  input  logic [31:0]       rsp_rdata,
  output logic              cpl_valid,
  output logic              cpl_abort,
  output logic [31:0]       cpl_rdata,
  output logic              wr_err
);
  localparam int ADDR_W   = 32;
  localparam int BUS_SH   = 16;
  localparam int SLOT_SH  = 11;
  localparam int FUNC_SH  = 8;

  function automatic logic [31:0] size_mask(input logic [1:0] s);
    case (s)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  logic              busy_q, t1_q, write_q;
  logic [31:0]       saved_q, addr_q, wdata_q;
  logic [3:0]        be_q;
  logic [1:0]        lane_q, size_q;

  wire is_t1    = (req_bus != '0);
  wire bad_slot = !is_t1 && (req_slot >= SLOT_W'(MAX_SLOTS));

  wire [ADDR_W-1:0] low_fields = (ADDR_W'(req_func) << FUNC_SH) | ADDR_W'(req_reg);
  wire [ADDR_W-1:0] addr_t1 = (ADDR_W'(req_bus) << BUS_SH) | (ADDR_W'(req_slot) << SLOT_SH) | low_fields;
  wire [ADDR_W-1:0] addr_t0 = (ADDR_W'(1) << (ADDR_W'(req_slot) + ADDR_W'(IDSEL_BASE))) | low_fields;

  wire [1:0] lane = (req_size == 2'd0) ? req_reg[1:0] :
                    (req_size == 2'd1) ? {req_reg[1], 1'b0} : 2'b00;
  wire [3:0] be   = (req_size == 2'd0) ? (4'b0001 << lane) :
                    (req_size == 2'd1) ? (4'b0011 << lane) : 4'b1111;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      t1_q      <= 1'b0;
      write_q   <= 1'b0;
      saved_q   <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      be_q      <= '0;
      lane_q    <= '0;
      size_q    <= '0;
      cpl_valid <= 1'b0;
      cpl_abort <= 1'b0;
      cpl_rdata <= '0;
      wr_err    <= 1'b0;
    end else begin
      cpl_valid <= 1'b0;
      wr_err    <= 1'b0;
      if (!busy_q && req_valid) begin
        if (bad_slot) begin
          cpl_valid <= 1'b1;
          cpl_abort <= 1'b1;
          cpl_rdata <= req_write ? 32'h0 : size_mask(req_size);
          wr_err    <= req_write;
        end else begin
          busy_q  <= 1'b1;
          t1_q    <= is_t1;
          write_q <= req_write;
          saved_q <= ctl_base;
          addr_q  <= is_t1 ? addr_t1 : addr_t0;
          be_q    <= be;
          lane_q  <= lane;
          size_q  <= req_size;
          wdata_q <= (req_wdata & size_mask(req_size)) << {lane, 3'b000};
        end
      end else if (busy_q && rsp_valid) begin
        busy_q    <= 1'b0;
        cpl_valid <= 1'b1;
        cpl_abort <= rsp_abort;
        cpl_rdata <= write_q ? 32'h0 :
                     rsp_abort ? size_mask(size_q) :
                     ((rsp_rdata >> {lane_q, 3'b000}) & size_mask(size_q));
        wr_err    <= write_q & rsp_abort;
      end
    end
  end

  assign busy      = busy_q;
  assign cyc_req   = busy_q;
  assign cyc_type1 = busy_q & t1_q;
  assign cyc_write = write_q;
  assign cyc_addr  = addr_q;
  assign cyc_be    = be_q;
  assign cyc_wdata = wdata_q;
  assign ext_ctl   = (busy_q && t1_q) ? (saved_q | (32'h1 << EXT_BIT)) : ctl_base;

  // R2
  idsel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_req && !cyc_type1 |-> $countones(cyc_addr[ADDR_W-1:IDSEL_BASE]) == 1);

  // R3
  ext_mode_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_req && cyc_type1 |-> ext_ctl[EXT_BIT]);

  // R3
  ext_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cyc_req) |-> ext_ctl == ctl_base);

  // R4
  bad_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !busy && req_bus == '0 && req_slot >= SLOT_W'(MAX_SLOTS)
    |=> cpl_valid && cpl_abort && !cyc_req);

  // R8
  wr_err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> cpl_valid && cpl_abort && !$past(wr_err));

  // R9
  hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_req && !rsp_valid |=> cyc_req && $stable(cyc_addr) && $stable(cyc_be));
endmodule

// File: tb/tb_cfg_cycle_former.sv
module tb_cfg_cycle_former;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [7:0]  req_bus = '0;
  logic [4:0]  req_slot = '0;
  logic [2:0]  req_func = '0;
  logic [7:0]  req_reg = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic [31:0] ctl_base = 32'h0000_1234;
  logic        busy, cyc_req, cyc_type1, cyc_write, cpl_valid, cpl_abort, wr_err;
  logic [31:0] ext_ctl, cyc_addr, cyc_wdata, cpl_rdata;
  logic [3:0]  cyc_be;
  logic        rsp_valid = 1'b0;
  logic        rsp_abort = 1'b0;
  logic [31:0] rsp_rdata = '0;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  cfg_cycle_former dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bus(req_bus),
    .req_slot(req_slot), .req_func(req_func), .req_reg(req_reg),
    .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .ctl_base(ctl_base), .busy(busy), .ext_ctl(ext_ctl), .cyc_req(cyc_req),
    .cyc_type1(cyc_type1), .cyc_write(cyc_write), .cyc_addr(cyc_addr),
    .cyc_be(cyc_be), .cyc_wdata(cyc_wdata), .rsp_valid(rsp_valid),
    .rsp_abort(rsp_abort), .rsp_rdata(rsp_rdata), .cpl_valid(cpl_valid),
    .cpl_abort(cpl_abort), .cpl_rdata(cpl_rdata), .wr_err(wr_err));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int width_bytes(input int size);
    return (size == 0) ? 1 : (size == 1) ? 2 : 4;
  endfunction

  task automatic run(input int bus, input int slot, input int func, input int rg,
                     input int size, input bit wr, input logic [31:0] wd,
                     input bit ab, input logic [31:0] rd);
    longint wmask, exp_addr, exp_rd;
    int nb, lane;
    logic [3:0] exp_be;
    bit bad;
    nb    = width_bytes(size);
    wmask = (64'd1 << (8 * nb)) - 1;
    lane  = (nb == 1) ? (rg % 4) : (nb == 2) ? ((rg / 2) % 2) * 2 : 0;
    exp_be = 4'((2 ** nb - 1) * (2 ** lane));
    bad   = (bus == 0) && (slot >= 12);
    if (bus != 0) exp_addr = bus * 65536 + slot * 2048 + func * 256 + rg;
    else          exp_addr = (64'd1 << (slot + 11)) + func * 256 + rg;
    @(negedge clk);
    req_valid = 1'b1; req_bus = 8'(bus); req_slot = 5'(slot); req_func = 3'(func);
    req_reg = 8'(rg); req_size = 2'(size); req_write = wr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    if (bad) begin
      check("R4 cpl_valid", 32'(cpl_valid), 32'd1);
      check("R4 no cyc_req", 32'(cyc_req), 32'd0);
      check("R4 cpl_abort", 32'(cpl_abort), 32'd1);
      check(wr ? "R8 bad-slot wr_err" : "R7 bad-slot rdata",
            wr ? 32'(wr_err) : cpl_rdata, wr ? 32'd1 : 32'(wmask));
      return;
    end
    check(bus != 0 ? "R1 address" : "R2 address", cyc_addr, 32'(exp_addr));
    check("R1 cyc_type1", 32'(cyc_type1), 32'(bus != 0));
    check("R9 busy", 32'(busy), 32'd1);
    check("R5 cyc_be", 32'(cyc_be), 32'(exp_be));
    if (wr) check("R5 cyc_wdata", cyc_wdata, 32'((longint'(wd) & wmask) << (8 * lane)));
    check("R3 ext_ctl during", ext_ctl, (bus != 0) ? (ctl_base | 32'h4000_0000) : ctl_base);
    rsp_valid = 1'b1; rsp_abort = ab; rsp_rdata = rd;
    @(negedge clk);
    rsp_valid = 1'b0; rsp_abort = 1'b0;
    exp_rd = wr ? 0 : ab ? wmask : ((longint'(rd) >> (8 * lane)) & wmask);
    check("R9 busy released", 32'(busy), 32'd0);
    check("R6 cpl_valid", 32'(cpl_valid), 32'd1);
    check("R7 cpl_abort", 32'(cpl_abort), 32'(ab));
    check(ab ? "R7 abort rdata" : "R6 rdata", cpl_rdata, 32'(exp_rd));
    check("R8 wr_err", 32'(wr_err), 32'(wr & ab));
    check("R3 ext_ctl restored", ext_ctl, ctl_base);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10
    check("R10 busy", 32'(busy), 32'd0);
    check("R10 cyc_req", 32'(cyc_req), 32'd0);
    check("R10 cpl_valid", 32'(cpl_valid), 32'd0);
    check("R10 wr_err", 32'(wr_err), 32'd0);

    for (int s = 0; s < 16; s++)
      for (int f = 0; f < 8; f += 3)
        run(0, s, f, (s * 20 + f * 4) % 256, 2, s[0], 32'hA5C3_0000 + 32'(s), 1'b0, 32'hDEAD_0000 + 32'(s));

    ctl_base = 32'h0F00_00F1;
    for (int b = 1; b < 256; b += 37)
      for (int s = 0; s < 32; s += 7)
        run(b, s, s % 8, (b + s * 4) % 256, 2, 1'b0, 32'h0, 1'b0, 32'h1357_9BDF);

    for (int sz = 0; sz < 4; sz++)
      for (int r = 0; r < 4; r++)
        for (int w = 0; w < 2; w++)
          for (int a = 0; a < 2; a++)
            run((sz + r) % 2, 3, 1, 8'h40 + r, sz, w[0], 32'h8877_6655, a[0], 32'hF1E2_D3C4);

    // R9: a second request during the wait is ignored
    @(negedge clk);
    req_valid = 1'b1; req_bus = 8'd2; req_slot = 5'd4; req_func = 3'd1;
    req_reg = 8'h10; req_size = 2'd2; req_write = 1'b0;
    @(negedge clk);
    req_bus = 8'd9; req_slot = 5'd7; req_reg = 8'h2C;
    @(negedge clk);
    check("R9 addr held", cyc_addr, 32'd2 * 65536 + 32'd4 * 2048 + 32'd256 + 32'h10);
    req_valid = 1'b0;
    rsp_valid = 1'b1; rsp_rdata = 32'h0BAD_F00D;
    @(negedge clk);
    rsp_valid = 1'b0;
    check("R9 completion", 32'(cpl_valid), 32'd1);
    @(negedge clk);
    check("R9 no second cycle", 32'(cyc_req), 32'd0);
    @(negedge clk);
    check("R9 still idle", 32'(busy), 32'd0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule